// File: doc/BRIEF.md
# Compressed Branch Resolver

This block takes one 16-bit compressed instruction word and, when the word belongs to the branch group, works out the next program counter in the same cycle. It also produces the side effects of the branch: a link-register write carrying the return address, and a count-register write carrying the decremented count. It reads the current condition, count and link registers and the current PC as plain inputs, and takes a single mode input that selects between the narrow (10-bit) and wide (16-bit) compressed encodings. The fetch unit or execute stage uses the result directly.

The two encoding words that mean "illegal" and "no operation" lie inside the unconditional-jump code space, so they are recognised before any branch field is interpreted. In wide mode, bits 15 (N) and 0 (M) of the word, together with a 4-bit extension field in bits 14:11, widen the offset and the condition-bit selector and unlock a conditional form with an immediate offset. Every target and fall-through address is forced to 2-byte alignment.

Top module: `cbr_resolver`

## Requirements
- R1: The word 16'h0000 raises `illegal_o` in either mode, and then no branch is taken, `lr_we_o` and `ctr_we_o` stay low and `next_pc_o` is PC+2.
- R2: The word 16'h0080 raises `nop_o` in either mode, with no branch, no register write and `next_pc_o` equal to PC+2.
- R3: In narrow mode a word with bits 10:8 = 000 (other than R1/R2) is an unconditional jump. Its signed offset is bits 6:1, counted in 2-byte units, and it is always taken to PC + 2*offset. Bits 15:11 and bit 0 have no effect.
- R4: In wide mode, with major 000 and {bit15, bit0} not equal to 11, the word is an unconditional jump with the 10-bit signed offset {bits 14:11, bits 6:1}, counted in 2-byte units.
- R5: In wide mode, with major 000 and {bit15, bit0} = 11, the word is a conditional jump. Its 6-bit signed offset is {bits 14:11, bits 2:1}. Bits 6:4 select condition bit `cr_i[7:0]`, and the jump is taken when that bit differs from bit 3. This form does not exist in narrow mode.
- R6: A word with bits 10:8 = 001 and bit 7 = 0 is a return-through-link branch to the link value with bit 0 cleared. Bit 3 enables the condition test, and bit 2 inverts it. In narrow mode bits 5:4 select `cr_i[3:0]`. With the test disabled, the condition counts as met.
- R7: In wide mode the return-through-link selector is {bits 12:11, bits 5:4}, which reaches `cr_i[15:0]`.
- R8: Bit 1 of a return-through-link word selects count mode. In count mode `ctr_we_o` is high, `ctr_wdata_o` = count-1, and the branch also requires count-1 to be non-zero. In wide mode, bit 13 = 1 reverses this test to count-1 equal to zero. No other form ever writes the count register.
- R9: The link bit of a branch is bit 7 for the jump forms and bit 6 for the return form. When it is set, `lr_we_o` is high whether or not the branch is taken, and `lr_wdata_o` = PC+2.
- R10: Words outside the branch group (major not 000, or major 001 with bit 7 = 1) give `is_branch_o` = 0, no register writes and `next_pc_o` = PC+2.
- R11: `next_pc_o` is always even, including when the PC input is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode16_i | input | 1 | 1 = wide 16-bit encoding, 0 = narrow 10-bit encoding |
| inst_i | input | 16 | compressed instruction word |
| cr_i | input | CRW | condition register, bit k = condition bit k |
| ctr_i | input | XLEN | count register |
| lr_i | input | XLEN | link register |
| pc_i | input | XLEN | address of the current instruction |
| is_branch_o | output | 1 | word decoded as a branch form |
| taken_o | output | 1 | branch taken |
| next_pc_o | output | XLEN | target when taken, else PC+2 |
| lr_we_o | output | 1 | link register write enable |
| lr_wdata_o | output | XLEN | return address |
| ctr_we_o | output | 1 | count register write enable |
| ctr_wdata_o | output | XLEN | decremented count |
| illegal_o | output | 1 | illegal word detected |
| nop_o | output | 1 | no-operation word detected |

## Verification
The embedded assertions check several properties on every evaluation:
- the illegal and no-operation words never cause a taken branch or a register write;
- the conditional-immediate form never appears in narrow mode;
- the selector stays inside its reach for each form;
- a taken return lands on the link value;
- any taken branch or register write implies a decoded branch.

Only the bench scenarios can show that the right offset bits are picked and sign-extended in each mode, and that condition inversion and the count test resolve correctly for particular register contents. The same applies to a word that means a jump in narrow mode but a conditional jump in wide mode.

// File: rtl/cbr_pkg.sv
// Package: shared encoding constants and decoded-field type for the
// compressed branch resolver. Assumes a 16-bit instruction word with
// bit 15 as the leftmost encoding bit.
package cbr_pkg;

    localparam int unsigned INST_W  = 16;
    localparam int unsigned OFFS_W  = 10;  // widest branch offset (wide jump)
    localparam int unsigned SEL_W   = 4;   // widest condition-bit selector
    localparam logic [INST_W-1:0] WORD_ILLEGAL = 16'h0000;
    localparam logic [INST_W-1:0] WORD_NOP     = 16'h0080;
    localparam logic [2:0] MAJ_JUMP = 3'b000;
    localparam logic [2:0] MAJ_REG  = 3'b001;

    typedef enum logic [2:0] {
        FORM_NONE,
        FORM_ILLEGAL,
        FORM_NOP,
        FORM_JUMP,
        FORM_CONDIMM,
        FORM_TOLINK
    } cbr_form_e;

    typedef struct packed {
        cbr_form_e          form;
        logic               link;      // write return address
        logic [OFFS_W-1:0]  offs;      // sign-extended, 2-byte units
        logic [SEL_W-1:0]   sel;       // condition bit index
        logic               chk_en;    // condition test enabled
        logic               chk_inv;   // condition test inverted
        logic               use_ctr;   // count mode
        logic               ctr_zero;  // count test wants zero
    } cbr_fields_t;

endpackage

// File: rtl/cbr_field_decode.sv
// Module: cbr_field_decode
// Classifies a compressed word into a branch form and extracts its
// fields for the selected mode. Illegal and no-operation words are
// matched on the whole word before any branch field is read.
// Assumes: purely combinational, no state.
module cbr_field_decode
    import cbr_pkg::*;
(
    input  logic                 mode16_i,
    input  logic [INST_W-1:0]    inst_i,
    output cbr_fields_t          fld_o
);

    localparam int unsigned NARROW_OFFS_W = 6;
    localparam int unsigned CIMM_OFFS_W   = 6;

    logic [2:0] major;
    logic       minor;
    logic       n_bit;
    logic       m_bit;
    logic [NARROW_OFFS_W-1:0] narrow_offs;
    logic [CIMM_OFFS_W-1:0]   cimm_offs;

    // Purpose: split the word into the fixed fields shared by all forms.
    always_comb begin
        major       = inst_i[10:8];
        minor       = inst_i[7];
        n_bit       = inst_i[15];
        m_bit       = inst_i[0];
        narrow_offs = inst_i[6:1];
        cimm_offs   = {inst_i[14:11], inst_i[2:1]};
    end

    // Purpose: choose the form and fill in its mode-dependent fields.
    always_comb begin
        fld_o          = '0;
        fld_o.form     = FORM_NONE;
        if (inst_i == WORD_ILLEGAL) begin
            fld_o.form = FORM_ILLEGAL;
        end else if (inst_i == WORD_NOP) begin
            fld_o.form = FORM_NOP;
        end else if (major == MAJ_JUMP) begin
            fld_o.link = minor;
            if (mode16_i && n_bit && m_bit) begin
                fld_o.form    = FORM_CONDIMM;
                fld_o.offs    = {{(OFFS_W-CIMM_OFFS_W){cimm_offs[CIMM_OFFS_W-1]}}, cimm_offs};
                fld_o.sel     = {1'b0, inst_i[6:4]};
                fld_o.chk_en  = 1'b1;
                fld_o.chk_inv = inst_i[3];
            end else begin
                fld_o.form = FORM_JUMP;
                if (mode16_i) begin
                    fld_o.offs = {inst_i[14:11], narrow_offs};
                end else begin
                    fld_o.offs = {{(OFFS_W-NARROW_OFFS_W){narrow_offs[NARROW_OFFS_W-1]}}, narrow_offs};
                end
            end
        end else if (major == MAJ_REG && !minor) begin
            fld_o.form     = FORM_TOLINK;
            fld_o.link     = inst_i[6];
            fld_o.sel      = mode16_i ? {inst_i[12:11], inst_i[5:4]} : {2'b00, inst_i[5:4]};
            fld_o.chk_en   = inst_i[3];
            fld_o.chk_inv  = inst_i[2];
            fld_o.use_ctr  = inst_i[1];
            fld_o.ctr_zero = mode16_i & inst_i[13];
        end
    end

    // Purpose: guard the mode restriction of the conditional-immediate form.
    always_comb begin
        assert_condimm_wide_only_R5: assert (fld_o.form != FORM_CONDIMM || mode16_i)
            else $error("conditional-immediate form decoded in narrow mode");
        assert_link_only_branch_R9: assert (!fld_o.link || fld_o.form == FORM_JUMP ||
                                            fld_o.form == FORM_CONDIMM || fld_o.form == FORM_TOLINK)
            else $error("link bit set on a non-branch form");
    end

endmodule

// File: rtl/cbr_cond_eval.sv
// Module: cbr_cond_eval
// Evaluates the condition-bit test and the count test of a decoded
// branch and produces the decremented count.
// Assumes: the selector already respects the reach of its form.
module cbr_cond_eval
    import cbr_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned CRW  = 32
) (
    input  logic               mode16_i,
    input  cbr_fields_t        fld_i,
    input  logic [CRW-1:0]     cr_i,
    input  logic [XLEN-1:0]    ctr_i,
    output logic               cond_ok_o,
    output logic               ctr_ok_o,
    output logic [XLEN-1:0]    ctr_next_o
);

    localparam int unsigned CR_REACH = (CRW < (1 << SEL_W)) ? CRW : (1 << SEL_W);

    logic cr_bit;
    logic ctr_nonzero;

    // Purpose: pick the selected condition bit, zero when out of reach.
    always_comb begin
        cr_bit = 1'b0;
        for (int k = 0; k < CR_REACH; k++) begin
            if (fld_i.sel == SEL_W'(k)) cr_bit = cr_i[k];
        end
    end

    // Purpose: resolve the condition test and its inversion.
    always_comb begin
        cond_ok_o = !fld_i.chk_en || (cr_bit ^ fld_i.chk_inv);
    end

    // Purpose: decrement the count and resolve the count test.
    always_comb begin
        ctr_next_o  = ctr_i - XLEN'(1);
        ctr_nonzero = |ctr_next_o;
        ctr_ok_o    = !fld_i.use_ctr || (fld_i.ctr_zero ? !ctr_nonzero : ctr_nonzero);
    end

    // Purpose: selector reach per form.
    always_comb begin
        assert_condimm_reach_R5: assert (fld_i.form != FORM_CONDIMM || fld_i.sel < SEL_W'(8))
            else $error("conditional-immediate selector beyond two fields");
        assert_narrow_reach_R6: assert (fld_i.form != FORM_TOLINK || mode16_i || fld_i.sel < SEL_W'(4))
            else $error("narrow return selector beyond first field");
    end

endmodule

// File: rtl/cbr_target_gen.sv
// Module: cbr_target_gen
// Forms the PC-relative target, the link target and the sequential
// address, each with bit 0 cleared.
// Assumes: offsets are sign-extended counts of 2-byte units.
module cbr_target_gen
    import cbr_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [OFFS_W-1:0]  offs_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [XLEN-1:0]    lr_i,
    output logic [XLEN-1:0]    rel_tgt_o,
    output logic [XLEN-1:0]    lr_tgt_o,
    output logic [XLEN-1:0]    seq_o
);

    localparam logic [XLEN-1:0] EVEN_MASK = ~XLEN'(1);
    localparam logic [XLEN-1:0] STEP      = XLEN'(2);

    logic [XLEN-1:0] pc_even;
    logic [XLEN-1:0] byte_offs;

    // Purpose: align the base and scale the offset to bytes.
    always_comb begin
        pc_even   = pc_i & EVEN_MASK;
        byte_offs = {{(XLEN-OFFS_W){offs_i[OFFS_W-1]}}, offs_i} << 1;
    end

    // Purpose: produce the three candidate addresses.
    always_comb begin
        rel_tgt_o = pc_even + byte_offs;
        lr_tgt_o  = lr_i & EVEN_MASK;
        seq_o     = pc_even + STEP;
    end

endmodule

// File: rtl/cbr_resolver.sv
// Module: cbr_resolver (top)
// Resolves the branch group of a compressed instruction in one
// combinational pass: decode, condition/count evaluation, target
// selection and register write-back requests.
// Assumes: the caller samples outputs for the word presented.
module cbr_resolver
    import cbr_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned CRW  = 32
) (
    input  logic               mode16_i,
    input  logic [15:0]        inst_i,
    input  logic [CRW-1:0]     cr_i,
    input  logic [XLEN-1:0]    ctr_i,
    input  logic [XLEN-1:0]    lr_i,
    input  logic [XLEN-1:0]    pc_i,
    output logic               is_branch_o,
    output logic               taken_o,
    output logic [XLEN-1:0]    next_pc_o,
    output logic               lr_we_o,
    output logic [XLEN-1:0]    lr_wdata_o,
    output logic               ctr_we_o,
    output logic [XLEN-1:0]    ctr_wdata_o,
    output logic               illegal_o,
    output logic               nop_o
);

    cbr_fields_t     fld;
    logic            cond_ok;
    logic            ctr_ok;
    logic [XLEN-1:0] ctr_next;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] lr_tgt;
    logic [XLEN-1:0] seq_pc;

    cbr_field_decode u_decode (
        .mode16_i (mode16_i),
        .inst_i   (inst_i),
        .fld_o    (fld)
    );

    cbr_cond_eval #(.XLEN(XLEN), .CRW(CRW)) u_cond (
        .mode16_i   (mode16_i),
        .fld_i      (fld),
        .cr_i       (cr_i),
        .ctr_i      (ctr_i),
        .cond_ok_o  (cond_ok),
        .ctr_ok_o   (ctr_ok),
        .ctr_next_o (ctr_next)
    );

    cbr_target_gen #(.XLEN(XLEN)) u_target (
        .offs_i    (fld.offs),
        .pc_i      (pc_i),
        .lr_i      (lr_i),
        .rel_tgt_o (rel_tgt),
        .lr_tgt_o  (lr_tgt),
        .seq_o     (seq_pc)
    );

    // Purpose: combine decode and evaluation into the resolved outcome.
    always_comb begin
        illegal_o   = (fld.form == FORM_ILLEGAL);
        nop_o       = (fld.form == FORM_NOP);
        is_branch_o = (fld.form == FORM_JUMP) || (fld.form == FORM_CONDIMM) ||
                      (fld.form == FORM_TOLINK);
        taken_o     = is_branch_o && cond_ok && ctr_ok;
        if (!taken_o)                    next_pc_o = seq_pc;
        else if (fld.form == FORM_TOLINK) next_pc_o = lr_tgt;
        else                             next_pc_o = rel_tgt;
        lr_we_o     = is_branch_o && fld.link;
        lr_wdata_o  = seq_pc;
        ctr_we_o    = is_branch_o && fld.use_ctr;
        ctr_wdata_o = ctr_next;
    end

    // Purpose: outcome-level guards.
    always_comb begin
        assert_illegal_inert_R1: assert (!illegal_o || (!taken_o && !lr_we_o && !ctr_we_o))
            else $error("illegal word caused a branch side effect");
        assert_nop_inert_R2: assert (!nop_o || (!taken_o && !lr_we_o && !ctr_we_o))
            else $error("no-operation word caused a branch side effect");
        assert_return_lands_on_link_R6: assert (!(taken_o && fld.form == FORM_TOLINK) ||
                                                next_pc_o[XLEN-1:1] == lr_i[XLEN-1:1])
            else $error("taken return did not land on link value");
        assert_count_only_return_R8: assert (!ctr_we_o || fld.form == FORM_TOLINK)
            else $error("count write from a non-return form");
        assert_taken_needs_branch_R10: assert (!(taken_o || lr_we_o) || is_branch_o)
            else $error("branch effect without a branch form");
        assert_even_next_R11: assert (next_pc_o[0] == 1'b0)
            else $error("next PC is odd");
    end

endmodule

// File: tb/cbr_resolver_bench.sv
// Bench: table-driven check of the compressed branch resolver followed
// by directed corner cases.
module cbr_resolver_bench;

    localparam int unsigned XLEN = 64;
    localparam int unsigned CRW  = 32;
    localparam int unsigned NV   = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            mode16;
    logic [15:0]     inst;
    logic [CRW-1:0]  cr;
    logic [XLEN-1:0] ctr, lr, pc;
    logic            is_branch, taken, lr_we, ctr_we, illegal, nop;
    logic [XLEN-1:0] next_pc, lr_wdata, ctr_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    cbr_resolver #(.XLEN(XLEN), .CRW(CRW)) u_cbr_resolver (
        .mode16_i (mode16), .inst_i (inst), .cr_i (cr), .ctr_i (ctr),
        .lr_i (lr), .pc_i (pc), .is_branch_o (is_branch), .taken_o (taken),
        .next_pc_o (next_pc), .lr_we_o (lr_we), .lr_wdata_o (lr_wdata),
        .ctr_we_o (ctr_we), .ctr_wdata_o (ctr_wdata), .illegal_o (illegal),
        .nop_o (nop)
    );

    // Layout: [42:39] req, [38] mode16, [37:22] word,
    // [21:16] taken,branch,lr_we,ctr_we,illegal,nop, [15:0] next PC.
    // Fixed context: pc=0x1000, lr=0x2001, ctr=5, cr=0x5A96.
    localparam logic [42:0] VEC [NV] = '{
        {4'd1,  1'b0, 16'h0000, 6'b000010, 16'h1002},  // R1
        {4'd1,  1'b1, 16'h0000, 6'b000010, 16'h1002},  // R1
        {4'd2,  1'b0, 16'h0080, 6'b000001, 16'h1002},  // R2
        {4'd2,  1'b1, 16'h0080, 6'b000001, 16'h1002},  // R2
        {4'd3,  1'b0, 16'h0006, 6'b110000, 16'h1006},  // R3 +3
        {4'd9,  1'b0, 16'h00FE, 6'b111000, 16'h0FFE},  // R9 / R3 -1 with link
        {4'd5,  1'b0, 16'hF807, 6'b110000, 16'h1006},  // R5 narrow: plain jump
        {4'd4,  1'b1, 16'h0800, 6'b110000, 16'h1080},  // R4 +64
        {4'd4,  1'b1, 16'hF87C, 6'b110000, 16'h0FFC},  // R4 -2
        {4'd5,  1'b1, 16'h8075, 6'b110000, 16'h1004},  // R5 bit7 set
        {4'd5,  1'b1, 16'h807D, 6'b010000, 16'h1002},  // R5 inverted
        {4'd5,  1'b1, 16'hF8D7, 6'b011000, 16'h1002},  // R5 bit5 clear, link
        {4'd5,  1'b1, 16'hF8DF, 6'b111000, 16'h0FFE},  // R5 inverted, -1
        {4'd6,  1'b0, 16'h0118, 6'b110000, 16'h2000},  // R6
        {4'd6,  1'b0, 16'h011C, 6'b010000, 16'h1002},  // R6 inverted
        {4'd9,  1'b0, 16'h0140, 6'b111000, 16'h2000},  // R9 / R6 test off
        {4'd6,  1'b0, 16'h0138, 6'b010000, 16'h1002},  // R6 bit3 clear
        {4'd7,  1'b1, 16'h1918, 6'b010000, 16'h1002},  // R7 selector 13
        {4'd7,  1'b0, 16'h1918, 6'b110000, 16'h2000},  // R7 narrow selector 1
        {4'd8,  1'b0, 16'h0102, 6'b110100, 16'h2000},  // R8 count 4 nonzero
        {4'd8,  1'b1, 16'h2102, 6'b010100, 16'h1002},  // R8 zero sense
        {4'd10, 1'b0, 16'h0200, 6'b000000, 16'h1002},  // R10
        {4'd10, 1'b1, 16'h0180, 6'b000000, 16'h1002},  // R10
        {4'd10, 1'b1, 16'h0781, 6'b000000, 16'h1002}   // R10
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic m, input logic [15:0] w);
        @(posedge clk);
        mode16 = m;
        inst   = w;
        @(negedge clk);
    endtask

    initial begin
        mode16 = 1'b0; inst = 16'h0000; cr = '0; ctr = '0; lr = '0; pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle inputs are the illegal word
        check(illegal == 1'b1 && taken == 1'b0, "R1", "reset idle illegal", {63'b0, illegal}, 64'd1);
        rst_n = 1'b1;

        cr = 32'h0000_5A96; ctr = 64'd5; lr = 64'h2001; pc = 64'h1000;
        for (int i = 0; i < NV; i++) begin
            string rq;
            logic [5:0] fl;
            rq = $sformatf("R%0d", VEC[i][42:39]);
            apply(VEC[i][38], VEC[i][37:22]);
            fl = {taken, is_branch, lr_we, ctr_we, illegal, nop};
            check(fl == VEC[i][21:16], rq, $sformatf("vec %0d flags", i),
                  {58'b0, fl}, {58'b0, VEC[i][21:16]});
            check(next_pc == {48'b0, VEC[i][15:0]}, rq, $sformatf("vec %0d next", i),
                  next_pc, {48'b0, VEC[i][15:0]});
        end

        // R9: return address is PC+2
        apply(1'b0, 16'h00FE);
        check(lr_wdata == 64'h1002, "R9", "return address", lr_wdata, 64'h1002);
        // R8: decremented count value
        apply(1'b0, 16'h0102);
        check(ctr_wdata == 64'd4, "R8", "count value", ctr_wdata, 64'd4);
        // R8: count reaching zero blocks narrow return
        ctr = 64'd1;
        apply(1'b0, 16'h0102);
        check(taken == 1'b0 && ctr_we == 1'b1, "R8", "count zero narrow",
              {63'b0, taken}, 64'd0);
        check(ctr_wdata == 64'd0, "R8", "count zero value", ctr_wdata, 64'd0);
        // R8: zero sense in wide mode takes it
        apply(1'b1, 16'h2102);
        check(taken == 1'b1 && next_pc == 64'h2000, "R8", "count zero wide",
              next_pc, 64'h2000);
        // R11: odd PC still gives even results
        ctr = 64'd5; pc = 64'h1001;
        apply(1'b0, 16'h0006);
        check(next_pc == 64'h1006, "R11", "odd pc jump", next_pc, 64'h1006);
        apply(1'b0, 16'h0200);
        check(next_pc == 64'h1002, "R11", "odd pc sequential", next_pc, 64'h1002);
        // R4: jump across an upper address boundary
        pc = 64'h0000_0001_0000_0000;
        apply(1'b1, 16'hF87C);
        check(next_pc == 64'h0000_0000_FFFF_FFFC, "R4", "negative across boundary",
              next_pc, 64'h0000_0000_FFFF_FFFC);
        // R3: upper bits ignored in narrow mode, most negative offset
        pc = 64'h1000;
        apply(1'b0, 16'h7840);
        check(next_pc == 64'h0FC0, "R3", "narrow most negative", next_pc, 64'h0FC0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule